// File: doc/BRIEF.md
# Descriptor Integrity Gate

This block sits between a descriptor fetch engine and a DMA channel scheduler. The fetcher hands it one 16-word descriptor, a 32-bit word at a time. The channel number travels with the first word. As the words arrive the gate keeps a running modular sum. It keeps the control word (word 0) and the completion flag from word 5.

When the final word arrives, the gate decides whether the channel may act on the descriptor. Three tests apply, in a fixed priority:
- the validity marker in the control word;
- an optional additive checksum;
- the completion flag, which the control word itself can override.

The gate reports the decision as a single-cycle result. The result carries:
- an accept flag;
- a 32-bit error vector in which each fault kind and channel has its own bit;
- a status word that unpacks the control fields into fixed positions;
- a chain-end flag that tells the scheduler whether to stop following next pointers.

A fetch-error input can abort a descriptor that is still arriving. The abort produces an immediate reject with the fetch-fault bit for that channel.

Top module: `desc_guard`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `res_valid`, `res_accept`, `res_chain_end`, `res_chan`, `res_err` and `res_status` are all zero.
- R2: Words are counted 0 to 15 on cycles with `in_valid` high. Idle cycles between words are allowed. The channel is taken from `in_chan` with word 0. `res_valid` is high for exactly the one cycle after word 15 is taken, and `res_chan` shows the channel.
- R3: A descriptor whose word 0 bits 7:0 differ from 0xA5 is rejected with `res_err` bit 7+n set, where n is the channel.
- R4: When word 0 bit 20 is set, the 32-bit wraparound sum of words 0 to 14 must equal word 15, or the descriptor is rejected with `res_err` bit 13+n. When bit 20 is clear, word 15 has no effect on the result.
- R5: When word 5 bit 31 (done) is set and word 0 bit 10 is clear, the descriptor is rejected with `res_err` bit 25+n. When word 0 bit 10 is set, the done bit causes no reject.
- R6: Only the first failing test is reported, in the order marker, checksum, done. `res_err` never has more than one bit set.
- R7: For every completed descriptor, `res_status` holds word 0 bits 7:0 at bits 20:13, together with these flags (all other bits zero):

  | `res_status` bit | Taken from |
  |---|---|
  | 4 | word 0 bit 11 |
  | 5 | word 0 bit 18 |
  | 6 | word 0 bit 20 |
  | 7 | word 0 bit 19 |
  | 8 | word 0 bit 21 |
  | 9 | word 0 bit 10 |
  | 10 | the done bit |
  | 11 | word 0 bit 9 |
  | 12 | word 0 bit 8 |
- R8: `res_chain_end` is set on any reject. On an accept it is set if word 0 bit 19 or bit 21 is set.
- R9: A cycle with `fetch_err` high aborts the descriptor in progress. Any word offered in that cycle is discarded. The next cycle shows a reject with only `res_err` bit 1+n set, `res_status` zero and `res_chain_end` set. The following word is treated as word 0. The channel n is `in_chan` if no word has yet been taken, otherwise the latched channel.
- R10: A descriptor that passes every test gives `res_accept` high and `res_err` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A descriptor word is offered this cycle |
| in_word | input | 32 | Descriptor word |
| in_chan | input | CH_W (3) | Channel number, taken with word 0 |
| fetch_err | input | 1 | The fetch of the current descriptor failed |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Descriptor may be processed |
| res_chan | output | CH_W (3) | Channel of the result |
| res_err | output | 32 | Per-channel fault bits |
| res_status | output | 32 | Status word built from the control fields |
| res_chain_end | output | 1 | Stop following the descriptor chain |

## Verification
The vector table sends full descriptors on every channel. It covers:
- a plain accept;
- a correct and a corrupted checksum;
- a corrupted word 15 with the checksum disabled, which shows that word 15 is ignored when the check is off;
- a bad marker;
- a done flag both with and without the override;
- each of the two chain-ending bits.

Two rows fail several tests at once. They tell the marker-over-checksum priority apart from the checksum-over-done priority.

Directed tests add:
- idle gaps inside a stream, to separate word counting from cycle counting;
- an abort in the middle of a stream, followed by a clean descriptor, to show that the abort resets the word count and reports the latched channel;
- an abort before any word, which must use the live channel input.

// File: rtl/desc_guard_pkg.sv
// desc_guard_pkg: shared constants and the status-word packer for the
// descriptor integrity gate. Assumes 32-bit descriptor words.
package desc_guard_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 16;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int LAST_IDX   = DESC_WORDS - 1;
    localparam int DONE_IDX   = 5;
    localparam int DONE_BIT   = 31;
    localparam logic [7:0] MARKER = 8'hA5;

    // control word bit positions
    localparam int C_INTR  = 8;
    localparam int C_UPD   = 9;
    localparam int C_IGN   = 10;
    localparam int C_BURST = 11;
    localparam int C_FRAG  = 18;
    localparam int C_LAST  = 19;
    localparam int C_CSUM  = 20;
    localparam int C_LOF   = 21;
    localparam int C_USED  = 22;

    // error vector bases, channel n adds n
    localparam int E_FETCH = 1;
    localparam int E_MARK  = 7;
    localparam int E_SUM   = 13;
    localparam int E_DONE  = 25;

    // status word positions
    localparam int S_BURST = 4;
    localparam int S_FRAG  = 5;
    localparam int S_CSUM  = 6;
    localparam int S_LAST  = 7;
    localparam int S_LOF   = 8;
    localparam int S_IGN   = 9;
    localparam int S_DONE  = 10;
    localparam int S_UPD   = 11;
    localparam int S_INTR  = 12;
    localparam int S_BYTE  = 13;

    typedef enum logic [1:0] {
        FAULT_NONE = 2'd0,
        FAULT_MARK = 2'd1,
        FAULT_SUM  = 2'd2,
        FAULT_DONE = 2'd3
    } fault_e;

    // Unpack control fields and the done flag into the status layout.
    function automatic logic [WORD_W-1:0] pack_status(
        input logic [C_USED-1:0] ctl,
        input logic              done
    );
        logic [WORD_W-1:0] s;
        s             = '0;
        s[S_BYTE+:8]  = ctl[7:0];
        s[S_BURST]    = ctl[C_BURST];
        s[S_FRAG]     = ctl[C_FRAG];
        s[S_CSUM]     = ctl[C_CSUM];
        s[S_LAST]     = ctl[C_LAST];
        s[S_LOF]      = ctl[C_LOF];
        s[S_IGN]      = ctl[C_IGN];
        s[S_DONE]     = done;
        s[S_UPD]      = ctl[C_UPD];
        s[S_INTR]     = ctl[C_INTR];
        return s;
    endfunction

endpackage

// File: rtl/desc_guard_collect.sv
// desc_guard_collect: counts incoming descriptor words, latches the
// channel, the used control bits and the done flag, and flags the last word.
// Assumes in_chan < NUM_CH whenever word 0 is offered.
module desc_guard_collect
    import desc_guard_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              fetch_err,
    output logic [IDX_W-1:0]  idx,
    output logic [CH_W-1:0]   act_chan,
    output logic [C_USED-1:0] ctl,
    output logic              done_flag,
    output logic              take,
    output logic              last_word
);

    logic [CH_W-1:0] chan_q;

    assign take      = in_valid && !fetch_err;
    assign last_word = take && (idx == IDX_W'(LAST_IDX));
    // channel of the descriptor: live input before word 0, latched after
    assign act_chan  = (idx == '0) ? in_chan : chan_q;

    // word index: advance on each taken word, restart on abort
    always_ff @(posedge clk) begin
        if (!rst_n || fetch_err) begin
            idx <= '0;
        end else if (in_valid) begin
            idx <= idx + 1'b1;
        end
    end

    // latch channel, control bits and done flag at their word positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q    <= '0;
            ctl       <= '0;
            done_flag <= 1'b0;
        end else if (take) begin
            if (idx == '0) begin
                chan_q <= in_chan;
                ctl    <= in_word[C_USED-1:0];
            end
            if (idx == IDX_W'(DONE_IDX)) begin
                done_flag <= in_word[DONE_BIT];
            end
        end
    end

    a_r2_index_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        last_word |=> (idx == '0));

    a_r9_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |=> (idx == '0));

    a_r2_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (take && idx == '0) |-> (int'(in_chan) < NUM_CH));

endmodule

// File: rtl/desc_guard_sum.sv
// desc_guard_sum: running 32-bit wraparound sum of words 0 to 14 of the
// descriptor being received. Word 15 is never added.
module desc_guard_sum
    import desc_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] acc
);

    // accumulate: load on word 0, add words 1..14, hold on word 15
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (take) begin
            if (idx == '0) begin
                acc <= in_word;
            end else if (idx != IDX_W'(LAST_IDX)) begin
                acc <= acc + in_word;
            end
        end
    end

    a_r4_hold_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && idx == IDX_W'(LAST_IDX)) |=> $stable(acc));

endmodule

// File: rtl/desc_guard_judge.sv
// desc_guard_judge: applies marker, checksum and done tests in priority order
// on the last word, or reports a fetch fault on abort, and registers the
// result. Assumes NUM_CH <= 6 so the per-channel error fields do not overlap.
module desc_guard_judge
    import desc_guard_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_word,
    input  logic              fetch_err,
    input  logic [CH_W-1:0]   act_chan,
    input  logic [C_USED-1:0] ctl,
    input  logic              done_flag,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] in_word,
    output logic              res_valid,
    output logic              res_accept,
    output logic [CH_W-1:0]   res_chan,
    output logic [WORD_W-1:0] res_err,
    output logic [WORD_W-1:0] res_status,
    output logic              res_chain_end
);

    fault_e            fault;
    logic [WORD_W-1:0] fault_vec;

    // pick the first failing test
    always_comb begin
        if (ctl[7:0] != MARKER) begin
            fault = FAULT_MARK;
        end else if (ctl[C_CSUM] && (acc != in_word)) begin
            fault = FAULT_SUM;
        end else if (done_flag && !ctl[C_IGN]) begin
            fault = FAULT_DONE;
        end else begin
            fault = FAULT_NONE;
        end
    end

    // place the fault at its per-channel bit
    always_comb begin
        fault_vec = '0;
        unique case (fault)
            FAULT_MARK: fault_vec[E_MARK + int'(act_chan)] = 1'b1;
            FAULT_SUM:  fault_vec[E_SUM  + int'(act_chan)] = 1'b1;
            FAULT_DONE: fault_vec[E_DONE + int'(act_chan)] = 1'b1;
            default:    fault_vec = '0;
        endcase
    end

    // register the verdict for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_accept    <= 1'b0;
            res_chan      <= '0;
            res_err       <= '0;
            res_status    <= '0;
            res_chain_end <= 1'b0;
        end else begin
            res_valid <= fetch_err || last_word;
            if (fetch_err) begin
                res_accept    <= 1'b0;
                res_chan      <= act_chan;
                res_err       <= WORD_W'(1) << (E_FETCH + int'(act_chan));
                res_status    <= '0;
                res_chain_end <= 1'b1;
            end else if (last_word) begin
                res_accept    <= (fault == FAULT_NONE);
                res_chan      <= act_chan;
                res_err       <= fault_vec;
                res_status    <= pack_status(ctl, done_flag);
                res_chain_end <= (fault != FAULT_NONE) || ctl[C_LAST] || ctl[C_LOF];
            end
        end
    end

    a_r6_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(res_err));

    a_r10_accept_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (res_err == '0));

    a_r8_reject_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> res_chain_end);

endmodule

// File: rtl/desc_guard.sv
// desc_guard: descriptor integrity gate. Receives 16 words per descriptor and
// issues an accept or reject with a per-channel error vector and status word
// one cycle after the last word or after a fetch abort.
module desc_guard
    import desc_guard_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              fetch_err,
    output logic              res_valid,
    output logic              res_accept,
    output logic [CH_W-1:0]   res_chan,
    output logic [31:0]       res_err,
    output logic [31:0]       res_status,
    output logic              res_chain_end
);

    logic [IDX_W-1:0]  idx;
    logic [CH_W-1:0]   act_chan;
    logic [C_USED-1:0] ctl;
    logic              done_flag;
    logic              take;
    logic              last_word;
    logic [WORD_W-1:0] acc;

    desc_guard_collect #(.NUM_CH(NUM_CH)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_chan   (in_chan),
        .fetch_err (fetch_err),
        .idx       (idx),
        .act_chan  (act_chan),
        .ctl       (ctl),
        .done_flag (done_flag),
        .take      (take),
        .last_word (last_word)
    );

    desc_guard_sum u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .idx     (idx),
        .in_word (in_word),
        .acc     (acc)
    );

    desc_guard_judge #(.NUM_CH(NUM_CH)) u_judge (
        .clk           (clk),
        .rst_n         (rst_n),
        .last_word     (last_word),
        .fetch_err     (fetch_err),
        .act_chan      (act_chan),
        .ctl           (ctl),
        .done_flag     (done_flag),
        .acc           (acc),
        .in_word       (in_word),
        .res_valid     (res_valid),
        .res_accept    (res_accept),
        .res_chan      (res_chan),
        .res_err       (res_err),
        .res_status    (res_status),
        .res_chain_end (res_chain_end)
    );

    a_r2_result_cause: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(last_word || fetch_err));

    initial begin
        a_r6_fields_fit: assert (NUM_CH >= 1 && NUM_CH <= 6);
    end

endmodule

// File: tb/test_desc_guard.sv
module test_desc_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [2:0]  in_chan = '0;
    logic        fetch_err = 1'b0;
    logic        res_valid, res_accept, res_chain_end;
    logic [2:0]  res_chan;
    logic [31:0] res_err, res_status;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    desc_guard i_desc_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_chan(in_chan), .fetch_err(fetch_err), .res_valid(res_valid),
        .res_accept(res_accept), .res_chan(res_chan), .res_err(res_err),
        .res_status(res_status), .res_chain_end(res_chain_end)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] w5;
        logic        bad_sum;
        logic [2:0]  ch;
        logic        acc;
        logic [1:0]  kind;   // 0 none, 1 marker, 2 checksum, 3 done
        logic        chain;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00A5, 32'h0000_0000, 1'b0, 3'd0, 1'b1, 2'd0, 1'b0},
        '{32'h0010_03A5, 32'h0000_0000, 1'b0, 3'd1, 1'b1, 2'd0, 1'b0},
        '{32'h0010_00A5, 32'h0000_0000, 1'b1, 3'd2, 1'b0, 2'd2, 1'b1},
        '{32'h0000_00A4, 32'h0000_0000, 1'b0, 3'd3, 1'b0, 2'd1, 1'b1},
        '{32'h0000_00A5, 32'h8000_0000, 1'b0, 3'd4, 1'b0, 2'd3, 1'b1},
        '{32'h0000_04A5, 32'h8000_0000, 1'b0, 3'd5, 1'b1, 2'd0, 1'b0},
        '{32'h0000_00A5, 32'h0000_0000, 1'b1, 3'd0, 1'b1, 2'd0, 1'b0},
        '{32'h0008_08A5, 32'h0000_0000, 1'b0, 3'd1, 1'b1, 2'd0, 1'b1},
        '{32'h0024_00A5, 32'h0000_0000, 1'b0, 3'd2, 1'b1, 2'd0, 1'b1},
        '{32'h0010_00C3, 32'h8000_0000, 1'b1, 3'd5, 1'b0, 2'd1, 1'b1},
        '{32'h0010_00A5, 32'h8000_0000, 1'b1, 3'd3, 1'b0, 2'd2, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_status(input logic [31:0] c, input logic d);
        logic [31:0] s = '0;
        s[20:13] = c[7:0];
        s[4]  = c[11];
        s[5]  = c[18];
        s[6]  = c[20];
        s[7]  = c[19];
        s[8]  = c[21];
        s[9]  = c[10];
        s[10] = d;
        s[11] = c[9];
        s[12] = c[8];
        return s;
    endfunction

    function automatic logic [31:0] fill_word(input int i, input logic [2:0] ch);
        return 32'h1357_0000 * i + 32'h0000_0911 * i + 32'(ch);
    endfunction

    // send a full descriptor; gaps inserts an idle cycle after every word
    task automatic send_desc(input logic [31:0] c, input logic [31:0] w5,
                             input logic bad_sum, input logic [2:0] ch, input bit gaps);
        logic [31:0] sum = '0;
        logic [31:0] w;
        for (int i = 0; i < 16; i++) begin
            if (i == 0) w = c;
            else if (i == 5) w = w5;
            else if (i == 15) w = bad_sum ? sum + 32'h0000_005A : sum;
            else w = fill_word(i, ch);
            if (i < 15) sum = sum + w;
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = w;
            in_chan  = (i == 0) ? ch : 3'd7 - ch;
            if (gaps && i < 15) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_word  = 32'hDEAD_BEEF;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = '0;
    endtask

    task automatic check_result(input string req, input logic [31:0] c, input logic [31:0] w5,
                                input logic [2:0] ch, input logic acc, input logic [1:0] kind,
                                input logic chain);
        logic [31:0] e = '0;
        case (kind)
            2'd1: e[7 + ch]  = 1'b1;
            2'd2: e[13 + ch] = 1'b1;
            2'd3: e[25 + ch] = 1'b1;
            default: e = '0;
        endcase
        chk({req, " R2 valid"}, 32'(res_valid), 32'd1);
        chk({req, " R2 chan"}, 32'(res_chan), 32'(ch));
        chk({req, " R10/R3-R6 accept"}, 32'(res_accept), 32'(acc));
        chk({req, " R6 err"}, res_err, e);
        chk({req, " R7 status"}, res_status, model_status(c, w5[31]));
        chk({req, " R8 chain"}, 32'(res_chain_end), 32'(chain));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero during reset and just after release
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(res_valid), 32'd0);
        chk("R1 err in reset", res_err, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", res_status, 32'd0);
        chk("R1 accept after reset", {res_accept, res_chain_end, res_chan}, 32'd0);

        // table: R3 marker, R4 checksum, R5 done, R6 priority, R7 status, R8 chain, R10 accept
        for (int v = 0; v < NV; v++) begin
            send_desc(VECS[v].ctrl, VECS[v].w5, VECS[v].bad_sum, VECS[v].ch, 1'b0);
            check_result($sformatf("vec%0d", v), VECS[v].ctrl, VECS[v].w5, VECS[v].ch,
                         VECS[v].acc, VECS[v].kind, VECS[v].chain);
            @(negedge clk);
            chk("R2 single-cycle pulse", 32'(res_valid), 32'd0);
        end

        // R2: idle gaps between words do not disturb counting or the sum
        send_desc(32'h0010_01A5, 32'h0000_0000, 1'b0, 3'd4, 1'b1);
        check_result("gaps", 32'h0010_01A5, 32'h0, 3'd4, 1'b1, 2'd0, 1'b0);

        // R9: abort mid-stream on channel 4, the word in that cycle is dropped
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = (i == 0) ? 32'h0000_00A5 : fill_word(i, 3'd4);
            in_chan  = (i == 0) ? 3'd4 : 3'd1;
        end
        @(negedge clk);
        fetch_err = 1'b1;
        in_word   = 32'h0000_00A5;
        in_chan   = 3'd1;
        @(negedge clk);
        fetch_err = 1'b0;
        in_valid  = 1'b0;
        chk("R9 abort valid", 32'(res_valid), 32'd1);
        chk("R9 abort err", res_err, 32'h0000_0020);
        chk("R9 abort accept", 32'(res_accept), 32'd0);
        chk("R9 abort status", res_status, 32'd0);
        chk("R9 abort chain", 32'(res_chain_end), 32'd1);
        chk("R9 abort chan", 32'(res_chan), 32'd4);

        // R9: after abort the next word is word 0 again
        send_desc(32'h0000_03A5, 32'h0000_0000, 1'b0, 3'd0, 1'b0);
        check_result("R9 restart", 32'h0000_03A5, 32'h0, 3'd0, 1'b1, 2'd0, 1'b0);

        // R9: abort before any word uses the live channel
        @(negedge clk);
        fetch_err = 1'b1;
        in_chan   = 3'd2;
        @(negedge clk);
        fetch_err = 1'b0;
        chk("R9 idle abort err", res_err, 32'h0000_0008);

        @(negedge clk);
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule